// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy Engine

This engine copies a rectangle of pixels from one place in a linear frame buffer to another. Pixel (x, y) sits at address `origin + y*pitch + x`. The copy is correct even when the source and target rectangles overlap. To achieve this, the engine picks a walk order before it starts. It walks bottom-up when the target lies lower than the source, and right-to-left when the target lies further right. Both choices are reported as a compact direction code.

Software loads the corners, the size, the pitch and the origin on the command inputs, then pulses `start`. The `busy` output stays high until the last pixel has been written. The engine reads one pixel per clock through a synchronous memory port with one cycle of read latency. It writes each pixel one cycle after its read. In key mode, source pixels equal to a programmed key colour are not written, so the target keeps its old content at those places.

Top module: `blit_engine`

## Requirements
- R1: After reset, `busy`, `mem_rd_en` and `mem_wr_en` are low. A `start` pulse seen while idle raises `busy` on the next cycle. `busy` stays high until the cycle that performs the last write, and it is low on the cycle after that.
- R2: A `start` pulse while `busy` is high is ignored: the running copy, its direction code, its span and its duration are unchanged.
- R3: The walk runs bottom-up exactly when `dst_top > src_top`. This case sets bit 2 of `sign_code`; otherwise bit 2 is 0.
- R4: The walk runs right-to-left exactly when `dst_left > src_left`. This case sets bit 0 of `sign_code`. Bit 1 is always 0, so the code takes the values 0, 1, 4 or 5.
- R5: Source pixel (x, y) is read from `origin + y*pitch + x`, and target pixel (x, y) is written at `origin + y*pitch + x`. Addresses wrap modulo 2^AW.
- R6: A copy moves `height+1` rows of `width` pixels each. With `width = 0`, nothing is written.
- R7: `dst_span` holds `((dst_left + width) << 16) | dst_left` for the accepted command, from the cycle after `start` onward.
- R8: With `key_en` high, a source pixel equal to `key_color` is not written; all other pixels are copied.
- R9: One pixel is moved per clock. For `width > 0`, `busy` is high for exactly `width*(height+1) + 1` cycles.
- R10: Every write happens exactly one cycle after the read that fetched its data.
- R11: For every overlap direction, the memory after the copy equals a copy made through a temporary buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command pulse, accepted only while idle |
| src_left | input | CW | Source left column |
| src_top | input | CW | Source top row |
| dst_left | input | CW | Target left column |
| dst_top | input | CW | Target top row |
| width | input | CW | Pixels per row |
| height | input | CW | Rows minus one |
| pitch | input | PW | Pixels per frame-buffer line |
| origin | input | AW | Address of pixel (0,0) |
| key_en | input | 1 | Enable colour-key skipping |
| key_color | input | DW | Key colour |
| busy | output | 1 | Copy in progress |
| sign_code | output | 3 | Walk direction: bit 0 right-to-left, bit 2 bottom-up |
| dst_span | output | 2*HW | Packed target horizontal bounds |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Write data |

## Verification
The bench aims at copies shifted by one pixel in each of the four directions, and at diagonal overlaps. A design that chose the wrong walk order would read pixels it had already overwritten, which would smear the rectangle. It also covers one-pixel rectangles, single rows and zero width, where an off-by-one in the row or column counters shows up as a missing or extra row or pixel, or as a wrong busy length. Key mode with many key-coloured pixels catches a filter that writes keyed pixels or drops the wrong ones. A start pulse issued mid-copy catches an engine that restarts or reloads its parameters.

// File: rtl/blit_pkg.sv
// Shared definitions for the rectangle copy engine.
// Assumes: the direction code is three bits wide and bit 1 is unused.
package blit_pkg;
    localparam int SGN_W       = 3;
    localparam int SGN_RTL_BIT = 0;
    localparam int SGN_UP_BIT  = 2;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_RUN   = 2'd1,
        WALK_DRAIN = 2'd2
    } walk_state_t;
endpackage

// File: rtl/blit_setup.sv
// Command decode: picks the overlap-safe walk order and derives the first
// source and target addresses, the signed row step and the packed span.
// Assumes: all inputs are held stable in the cycle start is sampled.
module blit_setup
    import blit_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 12,
    parameter int PW = 12,
    parameter int HW = 16
) (
    input  logic [CW-1:0]    src_left,
    input  logic [CW-1:0]    src_top,
    input  logic [CW-1:0]    dst_left,
    input  logic [CW-1:0]    dst_top,
    input  logic [CW-1:0]    width,
    input  logic [CW-1:0]    height,
    input  logic [PW-1:0]    pitch,
    input  logic [AW-1:0]    origin,
    output logic             rtl,
    output logic [SGN_W-1:0] sign,
    output logic [AW-1:0]    src_first,
    output logic [AW-1:0]    dst_first,
    output logic [AW-1:0]    step,
    output logic [2*HW-1:0]  span
);
    localparam int RW = CW + 1;

    logic          up;
    logic [RW-1:0] src_row0;
    logic [RW-1:0] dst_row0;
    logic [AW-1:0] src_start;
    logic [AW-1:0] dst_start;
    logic [AW-1:0] pitch_a;
    logic [AW-1:0] back_off;
    logic [RW-1:0] right_edge;

    // Direction choice: walk away from the side the target lies on.
    always_comb begin
        up  = (dst_top > src_top);
        rtl = (dst_left > src_left);
        sign = '0;
        sign[SGN_UP_BIT]  = up;
        sign[SGN_RTL_BIT] = rtl;
    end

    // First row: top row for downward walks, bottom row for upward walks.
    always_comb begin
        src_row0 = up ? (RW'(src_top) + RW'(height)) : RW'(src_top);
        dst_row0 = up ? (RW'(dst_top) + RW'(height)) : RW'(dst_top);
    end

    // Row start addresses and signed line step.
    always_comb begin
        pitch_a   = AW'(pitch);
        src_start = AW'(src_left) + pitch_a * AW'(src_row0) + origin;
        dst_start = AW'(dst_left) + pitch_a * AW'(dst_row0) + origin;
        step      = up ? (AW'(0) - pitch_a) : pitch_a;
    end

    // Right-to-left walks begin at the row end (start + width) minus one.
    always_comb begin
        back_off  = rtl ? (AW'(width) - AW'(1)) : AW'(0);
        src_first = src_start + back_off;
        dst_first = dst_start + back_off;
    end

    // Packed target bounds: right edge in the upper half, left edge below.
    always_comb begin
        right_edge = RW'(dst_left) + RW'(width);
        span = {HW'(right_edge), HW'(dst_left)};
    end
endmodule

// File: rtl/blit_walker.sv
// Address walker: steps one pixel per clock through the rectangle in the
// chosen order, issues reads, and carries each target address one stage
// so that the write lines up with the returning read data.
// Assumes: memory read latency of exactly one cycle.
module blit_walker
    import blit_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic          rtl,
    input  logic [AW-1:0] src_first,
    input  logic [AW-1:0] dst_first,
    input  logic [AW-1:0] step,
    output logic          accept,
    output logic          busy,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          pend_valid,
    output logic [AW-1:0] pend_addr
);
    walk_state_t   state;
    logic [AW-1:0] src_base;
    logic [AW-1:0] dst_base;
    logic [AW-1:0] src_ptr;
    logic [AW-1:0] dst_ptr;
    logic [AW-1:0] step_q;
    logic [CW-1:0] col_left;
    logic [CW-1:0] rows_left;
    logic [CW-1:0] last_col;
    logic          rtl_q;
    logic          row_done;
    logic [AW-1:0] hstep;

    // Handshake and strobes derived from the state register.
    always_comb begin
        accept   = start && (state == WALK_IDLE);
        busy     = (state != WALK_IDLE);
        rd_en    = (state == WALK_RUN);
        rd_addr  = src_ptr;
        row_done = (col_left == '0);
        hstep    = rtl_q ? {AW{1'b1}} : AW'(1);
    end

    // Walk state, pointers and row/column counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WALK_IDLE;
            src_base  <= '0;
            dst_base  <= '0;
            src_ptr   <= '0;
            dst_ptr   <= '0;
            step_q    <= '0;
            col_left  <= '0;
            rows_left <= '0;
            last_col  <= '0;
            rtl_q     <= 1'b0;
        end else begin
            case (state)
                WALK_IDLE: begin
                    if (accept) begin
                        state     <= (width == '0) ? WALK_DRAIN : WALK_RUN;
                        src_base  <= src_first;
                        dst_base  <= dst_first;
                        src_ptr   <= src_first;
                        dst_ptr   <= dst_first;
                        step_q    <= step;
                        col_left  <= width - CW'(1);
                        last_col  <= width - CW'(1);
                        rows_left <= height;
                        rtl_q     <= rtl;
                    end
                end
                WALK_RUN: begin
                    if (row_done) begin
                        if (rows_left == '0) begin
                            state <= WALK_DRAIN;
                        end else begin
                            rows_left <= rows_left - CW'(1);
                            col_left  <= last_col;
                            src_base  <= src_base + step_q;
                            dst_base  <= dst_base + step_q;
                            src_ptr   <= src_base + step_q;
                            dst_ptr   <= dst_base + step_q;
                        end
                    end else begin
                        col_left <= col_left - CW'(1);
                        src_ptr  <= src_ptr + hstep;
                        dst_ptr  <= dst_ptr + hstep;
                    end
                end
                WALK_DRAIN: begin
                    state <= WALK_IDLE;
                end
                default: begin
                    state <= WALK_IDLE;
                end
            endcase
        end
    end

    // One-stage carry of the target address alongside the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
        end else begin
            pend_valid <= (state == WALK_RUN);
            pend_addr  <= dst_ptr;
        end
    end
endmodule

// File: rtl/blit_keyfilt.sv
// Write stage: forwards returning read data to the target address and
// suppresses the write when key mode is on and the pixel equals the key.
// Assumes: key settings are latched for the whole copy.
module blit_keyfilt #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          pend_valid,
    input  logic [AW-1:0] pend_addr,
    input  logic [DW-1:0] rd_data,
    input  logic          key_on,
    input  logic [DW-1:0] key_val,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic keyed;

    // Key match and gated write strobe.
    always_comb begin
        keyed   = key_on && (rd_data == key_val);
        wr_en   = pend_valid && !keyed;
        wr_addr = pend_addr;
        wr_data = rd_data;
    end
endmodule

// File: rtl/blit_engine.sv
// Top level of the overlap-safe rectangle copy engine. Decodes a command,
// latches its direction, span and key settings on acceptance, and runs the
// walker and write stage against a synchronous one-port-each memory.
// Assumes: memory returns read data one cycle after mem_rd_en.
module blit_engine
    import blit_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 12,
    parameter int PW = 12,
    parameter int DW = 16,
    parameter int HW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CW-1:0]    src_left,
    input  logic [CW-1:0]    src_top,
    input  logic [CW-1:0]    dst_left,
    input  logic [CW-1:0]    dst_top,
    input  logic [CW-1:0]    width,
    input  logic [CW-1:0]    height,
    input  logic [PW-1:0]    pitch,
    input  logic [AW-1:0]    origin,
    input  logic             key_en,
    input  logic [DW-1:0]    key_color,
    output logic             busy,
    output logic [2:0]       sign_code,
    output logic [2*HW-1:0]  dst_span,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [DW-1:0]    mem_rd_data,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wr_data
);
    logic             set_rtl;
    logic [SGN_W-1:0] set_sign;
    logic [AW-1:0]    set_src;
    logic [AW-1:0]    set_dst;
    logic [AW-1:0]    set_step;
    logic [2*HW-1:0]  set_span;
    logic             accept;
    logic             pend_valid;
    logic [AW-1:0]    pend_addr;
    logic             key_en_q;
    logic [DW-1:0]    key_q;
    logic [SGN_W-1:0] sign_q;
    logic [2*HW-1:0]  span_q;

    blit_setup #(.AW(AW), .CW(CW), .PW(PW), .HW(HW)) u_setup (
        .src_left  (src_left),
        .src_top   (src_top),
        .dst_left  (dst_left),
        .dst_top   (dst_top),
        .width     (width),
        .height    (height),
        .pitch     (pitch),
        .origin    (origin),
        .rtl       (set_rtl),
        .sign      (set_sign),
        .src_first (set_src),
        .dst_first (set_dst),
        .step      (set_step),
        .span      (set_span)
    );

    blit_walker #(.AW(AW), .CW(CW)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .width      (width),
        .height     (height),
        .rtl        (set_rtl),
        .src_first  (set_src),
        .dst_first  (set_dst),
        .step       (set_step),
        .accept     (accept),
        .busy       (busy),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_rd_addr),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr)
    );

    blit_keyfilt #(.AW(AW), .DW(DW)) u_keyfilt (
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .rd_data    (mem_rd_data),
        .key_on     (key_en_q),
        .key_val    (key_q),
        .wr_en      (mem_wr_en),
        .wr_addr    (mem_wr_addr),
        .wr_data    (mem_wr_data)
    );

    // Command latch: direction, span and key settings held per copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q   <= '0;
            span_q   <= '0;
            key_en_q <= 1'b0;
            key_q    <= '0;
        end else if (accept) begin
            sign_q   <= set_sign;
            span_q   <= set_span;
            key_en_q <= key_en;
            key_q    <= key_color;
        end
    end

    // Status outputs.
    always_comb begin
        sign_code = sign_q;
        dst_span  = span_q;
    end
endmodule

// File: rtl/blit_engine_checker.sv
// Protocol checker for the rectangle copy engine, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module blit_engine_checker #(
    parameter int CW = 12,
    parameter int DW = 16,
    parameter int HW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [CW-1:0]   src_left,
    input logic [CW-1:0]   src_top,
    input logic [CW-1:0]   dst_left,
    input logic [CW-1:0]   dst_top,
    input logic            busy,
    input logic [2:0]      sign_code,
    input logic [2*HW-1:0] dst_span,
    input logic            mem_rd_en,
    input logic            mem_wr_en,
    input logic [DW-1:0]   mem_wr_data,
    input logic            key_en_q,
    input logic [DW-1:0]   key_q
);
    // R1: an idle start raises busy on the next cycle.
    assert_busy_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R1: memory strobes only while busy.
    assert_strobe_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> busy);

    // R2: a start while busy leaves the latched command untouched.
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(sign_code) && $stable(dst_span) && busy));

    // R3: the vertical bit follows the compared tops of the accepted command.
    assert_up_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sign_code[2] == ($past(dst_top) > $past(src_top))));

    // R4: the horizontal bit follows the compared lefts; bit 1 stays clear.
    assert_rtl_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ((sign_code[0] == ($past(dst_left) > $past(src_left)))
                         && !sign_code[1]));

    // R8: a key-coloured pixel never reaches the write port.
    assert_key_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !(key_en_q && (mem_wr_data == key_q)));

    // R10: each write follows a read by exactly one cycle.
    assert_write_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));
endmodule

bind blit_engine blit_engine_checker #(.CW(CW), .DW(DW), .HW(HW)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .src_left    (src_left),
    .src_top     (src_top),
    .dst_left    (dst_left),
    .dst_top     (dst_top),
    .busy        (busy),
    .sign_code   (sign_code),
    .dst_span    (dst_span),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_data (mem_wr_data),
    .key_en_q    (key_en_q),
    .key_q       (key_q)
);

// File: tb/blit_engine_bench.sv
// Bench for the rectangle copy engine: directed overlap corners plus seeded
// random copies, each compared against a buffered reference copy.
module blit_engine_bench;
    localparam int AW   = 20;
    localparam int CW   = 12;
    localparam int PW   = 12;
    localparam int DW   = 16;
    localparam int HW   = 16;
    localparam int MEMN = 4096;
    localparam int PITCH = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [CW-1:0]   src_left = '0, src_top = '0, dst_left = '0, dst_top = '0;
    logic [CW-1:0]   width = '0, height = '0;
    logic [PW-1:0]   pitch = PW'(PITCH);
    logic [AW-1:0]   origin = '0;
    logic            key_en = 1'b0;
    logic [DW-1:0]   key_color = '0;
    logic            busy;
    logic [2:0]      sign_code;
    logic [2*HW-1:0] dst_span;
    logic            mem_rd_en;
    logic [AW-1:0]   mem_rd_addr;
    logic [DW-1:0]   mem_rd_data;
    logic            mem_wr_en;
    logic [AW-1:0]   mem_wr_addr;
    logic [DW-1:0]   mem_wr_data;

    logic [DW-1:0] mem      [MEMN];
    logic [DW-1:0] init_mem [MEMN];
    logic [DW-1:0] exp_mem  [MEMN];
    logic [DW-1:0] tmp      [MEMN];
    logic          init_go = 1'b0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    blit_engine #(.AW(AW), .CW(CW), .PW(PW), .DW(DW), .HW(HW)) u_blit_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_left(src_left), .src_top(src_top), .dst_left(dst_left), .dst_top(dst_top),
        .width(width), .height(height), .pitch(pitch), .origin(origin),
        .key_en(key_en), .key_color(key_color),
        .busy(busy), .sign_code(sign_code), .dst_span(dst_span),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // Frame-buffer model: one-cycle read latency, old data on same-cycle hit.
    always @(posedge clk) begin
        if (init_go) begin
            for (int i = 0; i < MEMN; i++) mem[i] <= init_mem[i];
        end else begin
            if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];
            if (mem_wr_en) mem[mem_wr_addr[11:0]] <= mem_wr_data;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog R1 actual=%0d expected<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int addr_of(int org, int x, int y);
        return org + y * PITCH + x;
    endfunction

    // Reference copy through a temporary buffer, honouring key skipping.
    task automatic build_expect(int sl, int st, int dl, int dt, int w, int h,
                                int org, bit ke, int key);
        for (int i = 0; i < MEMN; i++) exp_mem[i] = init_mem[i];
        for (int y = 0; y <= h; y++)
            for (int x = 0; x < w; x++)
                tmp[y * w + x] = init_mem[addr_of(org, sl + x, st + y)];
        for (int y = 0; y <= h; y++)
            for (int x = 0; x < w; x++)
                if (!(ke && tmp[y * w + x] == DW'(key)))
                    exp_mem[addr_of(org, dl + x, dt + y)] = tmp[y * w + x];
    endtask

    task automatic run_case(int sl, int st, int dl, int dt, int w, int h, int org,
                            bit ke, int key, bit poke_busy, string tag);
        int cycles;
        int miss;
        int first_bad;
        logic [2:0] exp_sign;
        logic [31:0] exp_span;
        for (int i = 0; i < MEMN; i++) init_mem[i] = DW'($urandom);
        if (ke)
            for (int y = 0; y <= h; y++)
                for (int x = 0; x < w; x++)
                    if ($urandom % 3 == 0) init_mem[addr_of(org, sl + x, st + y)] = DW'(key);
        build_expect(sl, st, dl, dt, w, h, org, ke, key);
        @(negedge clk) init_go = 1'b1;
        @(negedge clk) init_go = 1'b0;
        src_left = CW'(sl); src_top = CW'(st); dst_left = CW'(dl); dst_top = CW'(dt);
        width = CW'(w); height = CW'(h); origin = AW'(org);
        key_en = ke; key_color = DW'(key);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        exp_sign = {(dt > st), 1'b0, (dl > sl)};
        exp_span = (32'(dl + w) << 16) | 32'(dl);
        check(busy == 1'b1, {"R1 busy after start ", tag}, busy, 1);
        check(sign_code == exp_sign, {"R3 R4 sign code ", tag}, sign_code, exp_sign);
        check(dst_span == exp_span, {"R7 span ", tag}, dst_span, exp_span);
        cycles = 0;
        while (busy && cycles < 5000) begin
            cycles++;
            if (poke_busy && cycles == 2) begin
                src_left = CW'(0); src_top = CW'(30); dst_left = CW'(40);
                dst_top = CW'(0); width = CW'(3); height = CW'(0);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (poke_busy)
            check(sign_code == exp_sign && dst_span == exp_span,
                  {"R2 start while busy ignored ", tag}, sign_code, exp_sign);
        check(cycles == ((w == 0) ? 1 : w * (h + 1) + 1),
              {"R9 R6 busy length ", tag}, cycles, (w == 0) ? 1 : w * (h + 1) + 1);
        miss = 0;
        first_bad = -1;
        for (int i = 0; i < MEMN; i++)
            if (mem[i] !== exp_mem[i]) begin
                miss++;
                if (first_bad < 0) first_bad = i;
            end
        if (first_bad < 0) first_bad = 0;
        check(miss == 0, {"R5 R8 R11 memory contents ", tag}, mem[first_bad], exp_mem[first_bad]);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMN; i++) init_mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(mem_rd_en == 1'b0 && mem_wr_en == 1'b0, "R1 reset strobes", mem_wr_en, 0);

        // R11 R4 one-pixel shifts in each direction, same rows
        run_case(10, 10, 11, 10, 8, 3, 5, 1'b0, 0, 1'b0, "shift right");
        run_case(10, 10,  9, 10, 8, 3, 5, 1'b0, 0, 1'b0, "shift left");
        // R11 R3 vertical shifts
        run_case(10, 10, 10, 11, 8, 3, 5, 1'b0, 0, 1'b0, "shift down");
        run_case(10, 10, 10,  9, 8, 3, 5, 1'b0, 0, 1'b0, "shift up");
        // R11 diagonal overlap, sign code 5
        run_case(10, 10, 12, 12, 6, 5, 0, 1'b0, 0, 1'b0, "diag rd");
        run_case(12, 12, 10, 10, 6, 5, 0, 1'b0, 0, 1'b0, "diag lu");
        // R6 single pixel, single row, zero width
        run_case(3, 4, 20, 2, 1, 0, 7, 1'b0, 0, 1'b0, "one pixel");
        run_case(3, 4, 5, 4, 12, 0, 7, 1'b0, 0, 1'b0, "one row");
        run_case(3, 4, 5, 6, 0, 2, 7, 1'b0, 0, 1'b0, "zero width");
        // R8 key mode
        run_case(8, 8, 9, 7, 7, 4, 3, 1'b1, 16'h5a5a, 1'b0, "key");
        // R2 start while busy
        run_case(15, 5, 14, 6, 6, 3, 9, 1'b0, 0, 1'b1, "poke");

        // Seeded random copies with nearby overlap
        for (int n = 0; n < 24; n++) begin
            int sl, st, dl, dt, w, h, org;
            sl = 5 + int'($urandom % 20);
            st = 5 + int'($urandom % 10);
            dl = sl + int'($urandom % 9) - 4;
            dt = st + int'($urandom % 9) - 4;
            w  = 1 + int'($urandom % 16);
            h  = int'($urandom % 10);
            org = int'($urandom % 64);
            run_case(sl, st, dl, dt, w, h, org, ($urandom % 3) == 0,
                     int'($urandom % 4), ($urandom % 5) == 0, "random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule